// File: doc/BRIEF.md
# Inter-processor message target selector

This block decides which of `NUM_UNITS` local interrupt controllers take part in an inter-processor message. A request carries a destination byte, an addressing-mode bit (physical or logical), a two-bit shorthand, the index of the sending unit and a flag that asks for lowest-priority delivery. Each unit presents its own physical ID, its logical ID, the encoding of its logical format register and an enable bit. Every unit checks these fields on its own, and together the units form a match set.

For ordinary delivery the match set is the result. For lowest-priority delivery a rotating-pointer arbiter cuts the set down to one unit. It prefers a matching unit that is enabled, searching from the unit after the previous winner. If no matching unit is enabled it falls back to the lowest-index match, and to unit 0 when nothing matches. The block registers the result and presents it with a valid strobe one clock after the request strobe. The message payload is handled elsewhere.

Top module: `ipi_target_sel`

## Requirements
- R1: With shorthand 0 and mode bit 0 (physical), a unit matches when the destination equals its physical ID or equals 8'hFF.
- R2: With shorthand 0 and mode bit 1 (logical), a unit whose format code is 2'b01 (flat) matches when the bitwise AND of its logical ID and the destination is non-zero.
- R3: With shorthand 0 and mode bit 1, a unit whose format code is 2'b10 (cluster) matches when bits [7:4] of its logical ID equal bits [7:4] of the destination and the AND of bits [3:0] of the two is non-zero.
- R4: With shorthand 0 and mode bit 1, a unit whose format code is 2'b00 or 2'b11 never matches.
- R5: Shorthand 1 selects only the sender, 2 selects every unit, and 3 selects every unit except the sender. In all three cases the destination, the mode bit and the unit IDs and formats have no effect.
- R6: Without lowest-priority delivery the accept mask equals the match set, whatever the unit enables are.
- R7: With lowest-priority delivery the units are searched in order starting after the stored pointer and wrapping around. The first unit that both matches and is enabled is the only bit set in the accept mask, and the pointer moves to that unit.
- R8: With lowest-priority delivery, if matching units exist but none is enabled, only the lowest-index matching unit is accepted and the pointer keeps its value.
- R9: With lowest-priority delivery and an empty match set, only unit 0 is accepted and the pointer keeps its value.
- R10: After synchronous reset the accept mask and the valid strobe are 0. The pointer is `NUM_UNITS-1`, so the first lowest-priority search begins at unit 0.
- R11: The valid strobe is high exactly in the cycle after a request strobe. The accept mask holds its value through cycles without a request, and a request without lowest-priority delivery does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe, one cycle |
| req_dest_i | input | 8 | Destination byte |
| req_logical_i | input | 1 | 0 physical, 1 logical addressing |
| req_shorthand_i | input | 2 | 0 destination field, 1 self, 2 all, 3 all but self |
| req_sender_i | input | IDX_W | Index of the sending unit |
| req_lowest_i | input | 1 | Lowest-priority delivery |
| unit_id_i | input | 8*NUM_UNITS | Physical ID per unit, unit k in bits [8k+7:8k] |
| unit_lid_i | input | 8*NUM_UNITS | Logical ID per unit |
| unit_fmt_i | input | 2*NUM_UNITS | Logical format code per unit |
| unit_en_i | input | NUM_UNITS | Unit enabled |
| accept_valid_o | output | 1 | Result valid, one cycle after the request |
| accept_o | output | NUM_UNITS | Per-unit accept mask |

## Verification
The bench concentrates on the wrap of the rotating search. When the stored pointer sits on the last unit, a design with an off-by-one in the start offset grants the previous winner again, or skips unit 0. The fallback paths are driven on purpose: matches with every enable low, and an empty match set. A design that moved the pointer there, or that returned an empty mask, would give the wrong winner in the next lowest-priority request. Logical requests go to units whose format codes are not valid, which catches a decoder that treats any non-flat code as cluster. Cluster requests use equal upper nibbles with disjoint lower nibbles, which catches a decoder that compares only the cluster field.

// File: rtl/ipi_sel_pkg.sv
package ipi_sel_pkg;
  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [1:0] FMT_FLAT    = 2'b01;
  localparam logic [1:0] FMT_CLUSTER = 2'b10;
  localparam logic [7:0] DEST_BCAST  = 8'hFF;
endpackage

// File: rtl/ipi_unit_match.sv
module ipi_unit_match
  import ipi_sel_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int UNIT  = 0
) (
  input  logic [7:0]       dest_i,
  input  logic             logical_i,
  input  logic [1:0]       shorthand_i,
  input  logic [IDX_W-1:0] sender_i,
  input  logic [7:0]       uid_i,
  input  logic [7:0]       ulid_i,
  input  logic [1:0]       ufmt_i,
  output logic             hit_o
);
  localparam logic [IDX_W-1:0] SELF_IDX = IDX_W'(UNIT);

  logic phys_hit, log_hit, is_self;

  assign is_self  = (sender_i == SELF_IDX);
  assign phys_hit = (dest_i == uid_i) || (dest_i == DEST_BCAST);

  always_comb begin
    case (ufmt_i)
      FMT_FLAT:    log_hit = |(ulid_i & dest_i);
      FMT_CLUSTER: log_hit = (ulid_i[7:4] == dest_i[7:4]) && (|(ulid_i[3:0] & dest_i[3:0]));
      default:     log_hit = 1'b0;
    endcase
  end

  always_comb begin
    case (shorthand_e'(shorthand_i))
      SH_DEST:   hit_o = logical_i ? log_hit : phys_hit;
      SH_SELF:   hit_o = is_self;
      SH_ALL:    hit_o = 1'b1;
      default:   hit_o = !is_self;
    endcase
  end

  always_comb begin
    if (!logical_i && shorthand_i == SH_DEST && dest_i == DEST_BCAST)
      AST_BCAST_HIT: assert (hit_o); // R1
    if (logical_i && shorthand_i == SH_DEST && ufmt_i != FMT_FLAT && ufmt_i != FMT_CLUSTER)
      AST_BADFMT_MISS: assert (!hit_o); // R4
  end
endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int NUM_UNITS = 4,
  parameter int IDX_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step_i,
  input  logic [NUM_UNITS-1:0] cand_i,
  input  logic [NUM_UNITS-1:0] elig_i,
  output logic [NUM_UNITS-1:0] grant_o
);
  localparam logic [IDX_W-1:0] PTR_INIT = IDX_W'(NUM_UNITS - 1);

  logic [IDX_W-1:0] ptr_q, win_idx, low_idx;
  logic             found, any_cand;

  always_comb begin
    found   = 1'b0;
    win_idx = ptr_q;
    for (int k = 1; k <= NUM_UNITS; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % NUM_UNITS;
      if (!found && cand_i[idx] && elig_i[idx]) begin
        found   = 1'b1;
        win_idx = IDX_W'(idx);
      end
    end
  end

  always_comb begin
    any_cand = 1'b0;
    low_idx  = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (!any_cand && cand_i[i]) begin
        any_cand = 1'b1;
        low_idx  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    grant_o = '0;
    grant_o[found ? win_idx : low_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                  ptr_q <= PTR_INIT;
    else if (step_i && found) ptr_q <= win_idx;
  end

  AST_GRANT_ELIG: assert property (@(posedge clk) disable iff (rst)
    (step_i && |(cand_i & elig_i)) |-> |(grant_o & cand_i & elig_i)); // R7
  AST_PTR_KEEP_NOELIG: assert property (@(posedge clk) disable iff (rst)
    (step_i && !(|(cand_i & elig_i))) |=> $stable(ptr_q)); // R8
  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(ptr_q)); // R11
  AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    step_i |-> $countones(grant_o) == 1); // R9
endmodule

// File: rtl/ipi_target_sel.sv
module ipi_target_sel
  import ipi_sel_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int IDX_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid_i,
  input  logic [7:0]             req_dest_i,
  input  logic                   req_logical_i,
  input  logic [1:0]             req_shorthand_i,
  input  logic [IDX_W-1:0]       req_sender_i,
  input  logic                   req_lowest_i,
  input  logic [8*NUM_UNITS-1:0] unit_id_i,
  input  logic [8*NUM_UNITS-1:0] unit_lid_i,
  input  logic [2*NUM_UNITS-1:0] unit_fmt_i,
  input  logic [NUM_UNITS-1:0]   unit_en_i,
  output logic                   accept_valid_o,
  output logic [NUM_UNITS-1:0]   accept_o
);
  logic [NUM_UNITS-1:0] hit_vec, grant_vec, next_accept;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    ipi_unit_match #(.IDX_W(IDX_W), .UNIT(u)) match_i (
      .dest_i      (req_dest_i),
      .logical_i   (req_logical_i),
      .shorthand_i (req_shorthand_i),
      .sender_i    (req_sender_i),
      .uid_i       (unit_id_i[8*u +: 8]),
      .ulid_i      (unit_lid_i[8*u +: 8]),
      .ufmt_i      (unit_fmt_i[2*u +: 2]),
      .hit_o       (hit_vec[u])
    );
  end

  ipi_rr_pick #(.NUM_UNITS(NUM_UNITS), .IDX_W(IDX_W)) pick_i (
    .clk     (clk),
    .rst     (rst),
    .step_i  (req_valid_i && req_lowest_i),
    .cand_i  (hit_vec),
    .elig_i  (unit_en_i),
    .grant_o (grant_vec)
  );

  assign next_accept = req_lowest_i ? grant_vec : hit_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      accept_valid_o <= 1'b0;
      accept_o       <= '0;
    end else begin
      accept_valid_o <= req_valid_i;
      if (req_valid_i) accept_o <= next_accept;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid_i |=> accept_valid_o); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> (!accept_valid_o && $stable(accept_o))); // R11
  AST_SELF_ONLY: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_shorthand_i == SH_SELF) |-> $onehot0(hit_vec)); // R5
  AST_OTHERS_SKIP: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !req_lowest_i && req_shorthand_i == SH_OTHERS && int'(req_sender_i) < NUM_UNITS)
      |=> !accept_o[$past(req_sender_i)]); // R5
  AST_LP_ONE: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_lowest_i) |=> $countones(accept_o) == 1); // R7
endmodule

// File: tb/ipi_target_sel_tb.sv
module ipi_target_sel_tb_top;
  localparam int N  = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_logical, req_lowest;
  logic [7:0] req_dest;
  logic [1:0] req_sh;
  logic [IW-1:0] req_sender;
  logic [8*N-1:0] uid, ulid;
  logic [2*N-1:0] ufmt;
  logic [N-1:0] uen;
  logic acc_valid;
  logic [N-1:0] acc;

  int n_chk = 0;
  int n_bad = 0;
  int m_ptr;
  logic [N-1:0] last_exp;

  always #10 clk = ~clk;

  ipi_target_sel #(.NUM_UNITS(N)) dut_i (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_dest_i(req_dest),
    .req_logical_i(req_logical), .req_shorthand_i(req_sh), .req_sender_i(req_sender),
    .req_lowest_i(req_lowest), .unit_id_i(uid), .unit_lid_i(ulid), .unit_fmt_i(ufmt),
    .unit_en_i(uen), .accept_valid_o(acc_valid), .accept_o(acc)
  );

  task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  function automatic logic unit_hit(int u);
    logic [7:0] id, li;
    logic [1:0] f;
    id = uid[8*u +: 8]; li = ulid[8*u +: 8]; f = ufmt[2*u +: 2];
    case (req_sh)
      2'd1: return int'(req_sender) == u;
      2'd2: return 1'b1;
      2'd3: return int'(req_sender) != u;
      default: begin
        if (!req_logical) return (req_dest == id) || (req_dest == 8'hFF);
        if (f == 2'b01) return |(li & req_dest);
        if (f == 2'b10) return (li[7:4] == req_dest[7:4]) && |(li[3:0] & req_dest[3:0]);
        return 1'b0;
      end
    endcase
  endfunction

  function automatic logic [N-1:0] model_expect();
    logic [N-1:0] m, r;
    int low;
    for (int u = 0; u < N; u++) m[u] = unit_hit(u);
    if (!req_lowest) return m;
    r = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (m_ptr + k) % N;
      if (m[idx] && uen[idx]) begin
        r[idx] = 1'b1;
        m_ptr = idx;
        return r;
      end
    end
    low = 0;
    for (int u = N - 1; u >= 0; u--) if (m[u]) low = u;
    r[low] = 1'b1;
    return r;
  endfunction

  task automatic send(input string tag, input logic [7:0] d, input logic lg,
                      input logic [1:0] sh, input int snd, input logic lp);
    logic [N-1:0] e;
    @(negedge clk);
    req_dest = d; req_logical = lg; req_sh = sh; req_sender = IW'(snd); req_lowest = lp;
    req_valid = 1'b1;
    e = model_expect();
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, {{(N-1){1'b0}}, acc_valid}, {{(N-1){1'b0}}, 1'b1});
    check(tag, acc, e);
    last_exp = e;
  endtask

  task automatic set_unit(int u, logic [7:0] id, logic [7:0] li, logic [1:0] f, logic en);
    uid[8*u +: 8] = id; ulid[8*u +: 8] = li; ufmt[2*u +: 2] = f; uen[u] = en;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; req_valid = 1'b0; req_dest = '0; req_logical = 1'b0; req_sh = '0;
    req_sender = '0; req_lowest = 1'b0; uid = '0; ulid = '0; ufmt = '0; uen = '0;
    m_ptr = N - 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset mask", acc, '0);
    check("R10 reset valid", {{(N-1){1'b0}}, acc_valid}, '0);

    for (int u = 0; u < N; u++) set_unit(u, 8'(u + 1), 8'(1 << u), 2'b01, 1'b1);
    send("R10 first lp starts at unit 0", 8'h00, 1'b0, 2'd2, 0, 1'b1);
    send("R1 physical id", 8'h03, 1'b0, 2'd0, 0, 1'b0);
    send("R1 physical bcast", 8'hFF, 1'b0, 2'd0, 0, 1'b0);
    send("R2 flat", 8'h05, 1'b1, 2'd0, 0, 1'b0);
    set_unit(0, 8'h10, 8'h31, 2'b10, 1'b1);
    set_unit(1, 8'h11, 8'h32, 2'b10, 1'b1);
    set_unit(2, 8'h12, 8'h21, 2'b10, 1'b1);
    set_unit(3, 8'h13, 8'h3F, 2'b00, 1'b1);
    send("R3 cluster", 8'h31, 1'b1, 2'd0, 0, 1'b0);
    send("R3 cluster disjoint low", 8'h34, 1'b1, 2'd0, 0, 1'b0);
    set_unit(3, 8'h13, 8'h3F, 2'b11, 1'b1);
    send("R4 bad format", 8'h3F, 1'b1, 2'd0, 0, 1'b0);
    send("R5 self", 8'hFF, 1'b0, 2'd1, 2, 1'b0);
    send("R5 all", 8'h00, 1'b1, 2'd2, 1, 1'b0);
    send("R5 others", 8'hFF, 1'b0, 2'd3, 3, 1'b0);
    uen = '0;
    send("R6 enables ignored", 8'hFF, 1'b0, 2'd0, 0, 1'b0);
    send("R8 no enabled match", 8'h00, 1'b0, 2'd3, 0, 1'b1);
    send("R9 empty set", 8'h77, 1'b0, 2'd0, 0, 1'b1);
    uen = 4'b1111;
    send("R7 rotate a", 8'hFF, 1'b0, 2'd0, 0, 1'b1);
    send("R7 rotate b", 8'hFF, 1'b0, 2'd0, 0, 1'b1);
    send("R7 rotate c", 8'hFF, 1'b0, 2'd0, 0, 1'b1);
    send("R7 wrap", 8'hFF, 1'b0, 2'd0, 0, 1'b1);
    send("R11 non-lp keeps pointer", 8'hFF, 1'b0, 2'd0, 0, 1'b0);
    send("R7 after non-lp", 8'hFF, 1'b0, 2'd0, 0, 1'b1);
    @(negedge clk);
    check("R11 hold mask", acc, last_exp);
    check("R11 valid low when idle", {{(N-1){1'b0}}, acc_valid}, '0);

    for (int t = 0; t < 400; t++) begin
      for (int u = 0; u < N; u++)
        set_unit(u, 8'($urandom_range(0, 5)), 8'($urandom_range(0, 255)) & 8'h3F,
                 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      send("R1-R9 random", ($urandom_range(0, 7) == 0) ? 8'hFF : 8'($urandom_range(0, 63)),
           1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), $urandom_range(0, N - 1),
           1'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        check("R11 random hold", acc, last_exp);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule